// File: doc/BRIEF.md
# Multi-Pin Wakeup Debounce Unit

This block watches a group of external wakeup pins on a slow (nominally 32 kHz) clock. Each pin has its own enable bit and its own active-level bit. A single coded setting, shared by all pins, chooses how many consecutive slow-clock cycles a pin must stay active before it counts. Every pin keeps its own run-length counter, so pins qualify independently of one another. A pin that qualifies while enabled sets its bit in a sticky cause register. A single request output stays high while any cause bit is set.

Software reaches the block through a simple port on the same clock. A write port has a strobe, a 2-bit address and a byte of data. A combinational read port returns 16 bits. Address 0 holds the debounce code, address 1 the active levels, address 2 the enables and address 3 the cause bits. The cause bits are cleared by writing ones to them. Each pin passes through a two-flop synchronizer before it is filtered.

Top module: `wkdb_top`

## Requirements
- R1: After reset, all four registers read 0x0000 and `wake_req` is low.
- R2: The debounce code register keeps the low 5 bits of a write, so writing 0xFF reads back 0x001F. The level and enable registers keep all 8 written bits. Bits 15:8 of every read are zero.
- R3: A pin is active when its synchronized level equals its level bit. Bit value 1 means active high and 0 means active low. A pin at the other level never sets its cause bit.
- R4: Each pin is sampled through two flops. With code 0, a pin that turns active just before rising edge A reads as a cause at the third rising edge counted from A, and not earlier.
- R5: With code 0 there is no filtering. A single synchronized cycle of activity sets the cause bit.
- R6: Codes 1 to 6 require runs of LEN_C1 to LEN_C6 cycles (by default 2, 3, 32, 512, 4096 and 32768). An active run of K cycles sets the cause bit exactly when K is at least the selected length.
- R7: Codes 7 to 31 behave like code 6.
- R8: A pin's counter restarts whenever the pin goes inactive. Two runs shorter than the length, separated by one inactive cycle, do not qualify.
- R9: A pin whose enable bit is 0 never sets its cause bit.
- R10: Cause bits are sticky. Writing 1 to a cause bit clears it, and writing 0 leaves it unchanged. When a pin qualifies in the same cycle that its bit is cleared, the set takes priority.
- R11: `wake_req` is high exactly when at least one cause bit is set.
- R12: Each pin's length is counted on its own. Pins that are active at the same time but for different run lengths qualify separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 code, 1 level, 2 enable, 3 cause) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| wake_pin | input | 8 | Raw asynchronous wakeup pins |
| wake_req | output | 1 | High while any cause bit is set |

## Verification
The bench builds the block with the six run lengths shrunk to 2, 3, 5, 7, 9 and 12. This keeps every code distinct while bringing the longest setting, and the reserved codes folded onto it, within a few dozen cycles. At those lengths the bench can place a run exactly at its length and one cycle short of it, and it can test saturation of the per-pin counters. A random phase with long and short pin runs, mixed with register writes, is compared every cycle against a reference model built from the requirements.

// File: rtl/wkdb_pkg.sv
// Shared constants for the wakeup debounce unit: register addresses.
package wkdb_pkg;
    localparam int unsigned ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CODE  = 2'd0;
    localparam logic [ADDR_W-1:0] A_LEVEL = 2'd1;
    localparam logic [ADDR_W-1:0] A_EN    = 2'd2;
    localparam logic [ADDR_W-1:0] A_CAUSE = 2'd3;
endpackage

// File: rtl/wkdb_sync.sv
// Two-flop synchronizer, one lane per bit.
// Assumes: inputs are asynchronous to clk; the reset value is 0 in both stages.
module wkdb_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/wkdb_run_filter.sv
// Per-pin run-length qualifier. It counts consecutive active cycles and
// asserts qual while the current cycle completes a run of at least run_len.
// Assumes: run_len >= 1; the counter saturates at all ones.
module wkdb_run_filter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [CNT_W-1:0] run_len,
    output logic             qual
);
    logic [CNT_W-1:0] run_q;

    // Count active cycles, restart on an inactive cycle, hold at saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!active) begin
            run_q <= '0;
        end else if (run_q != '1) begin
            run_q <= run_q + 1'b1;
        end
    end

    // This cycle is the run_len-th or later consecutive active cycle.
    assign qual = active && (run_q >= (run_len - CNT_W'(1)));
endmodule

// File: rtl/wkdb_regs.sv
// Register file: debounce code, active levels, enables and the sticky
// cause bits. Reads are combinational and padded with zeros to REG_W.
// Assumes: DATA_W >= NUM_PINS and DATA_W >= CODE_W; REG_W > NUM_PINS.
module wkdb_regs
    import wkdb_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned CODE_W   = 5,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned REG_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [REG_W-1:0]    rd_data,
    input  logic [NUM_PINS-1:0] set_vec,
    output logic [CODE_W-1:0]   code_q,
    output logic [NUM_PINS-1:0] level_q,
    output logic [NUM_PINS-1:0] en_q,
    output logic [NUM_PINS-1:0] cause_q
);
    logic [NUM_PINS-1:0] clr_vec;

    // Ones written to the cause address select the bits to clear.
    assign clr_vec = (wr_en && (wr_addr == A_CAUSE)) ? wr_data[NUM_PINS-1:0] : '0;

    // Configuration registers, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            level_q <= '0;
            en_q    <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CODE:  code_q  <= wr_data[CODE_W-1:0];
                A_LEVEL: level_q <= wr_data[NUM_PINS-1:0];
                A_EN:    en_q    <= wr_data[NUM_PINS-1:0];
                default: ;
            endcase
        end
    end

    // Sticky cause bits: clear on a written one, and a new set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= (cause_q & ~clr_vec) | set_vec;
        end
    end

    // Read multiplexer with zero padding.
    always_comb begin
        case (rd_addr)
            A_CODE:  rd_data = REG_W'(code_q);
            A_LEVEL: rd_data = REG_W'(level_q);
            A_EN:    rd_data = REG_W'(en_q);
            default: rd_data = REG_W'(cause_q);
        endcase
    end
endmodule

// File: rtl/wkdb_top.sv
// Multi-pin wakeup debounce unit. It synchronizes the pins, qualifies each
// against a shared coded run length and latches the result into cause bits.
// Assumes: a single slow clock for pins and register port;
// LEN_C6 is the largest length and every length is >= 1.
module wkdb_top
    import wkdb_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned CODE_W   = 5,
    parameter int unsigned REG_W    = 16,
    parameter int unsigned LEN_C1   = 2,
    parameter int unsigned LEN_C2   = 3,
    parameter int unsigned LEN_C3   = 32,
    parameter int unsigned LEN_C4   = 512,
    parameter int unsigned LEN_C5   = 4096,
    parameter int unsigned LEN_C6   = 32768
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [((NUM_PINS > CODE_W) ? NUM_PINS : CODE_W)-1:0] wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [REG_W-1:0]    rd_data,
    input  logic [NUM_PINS-1:0] wake_pin,
    output logic                wake_req
);
    localparam int unsigned DATA_W = (NUM_PINS > CODE_W) ? NUM_PINS : CODE_W;
    localparam int unsigned CNT_W  = $clog2(LEN_C6 + 1);

    logic [CODE_W-1:0]   code_q;
    logic [NUM_PINS-1:0] level_q;
    logic [NUM_PINS-1:0] en_q;
    logic [NUM_PINS-1:0] cause_q;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pin_active;
    logic [NUM_PINS-1:0] pin_qual;
    logic [NUM_PINS-1:0] set_vec;
    logic [CNT_W-1:0]    run_len;

    wkdb_sync #(.W(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (wake_pin),
        .d_sync  (pin_sync)
    );

    // Decode the shared code into a run length; reserved codes take the longest.
    always_comb begin
        case (code_q)
            0:       run_len = CNT_W'(1);
            1:       run_len = CNT_W'(LEN_C1);
            2:       run_len = CNT_W'(LEN_C2);
            3:       run_len = CNT_W'(LEN_C3);
            4:       run_len = CNT_W'(LEN_C4);
            5:       run_len = CNT_W'(LEN_C5);
            default: run_len = CNT_W'(LEN_C6);
        endcase
    end

    // A pin is active when its synchronized level matches its level bit.
    assign pin_active = ~(pin_sync ^ level_q);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        wkdb_run_filter #(.CNT_W(CNT_W)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (pin_active[p]),
            .run_len (run_len),
            .qual    (pin_qual[p])
        );
    end

    // Only enabled pins may raise a cause.
    assign set_vec = pin_qual & en_q;

    wkdb_regs #(
        .NUM_PINS (NUM_PINS),
        .CODE_W   (CODE_W),
        .DATA_W   (DATA_W),
        .REG_W    (REG_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .set_vec (set_vec),
        .code_q  (code_q),
        .level_q (level_q),
        .en_q    (en_q),
        .cause_q (cause_q)
    );

    assign wake_req = |cause_q;
endmodule

// File: rtl/wkdb_checker.sv
// Property checker for wkdb_top, attached by bind.
module wkdb_checker
    import wkdb_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned REG_W    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [REG_W-1:0]    rd_data,
    input logic                wake_req,
    input logic [NUM_PINS-1:0] cause_q,
    input logic [NUM_PINS-1:0] en_q,
    input logic [NUM_PINS-1:0] active
);
    logic [NUM_PINS-1:0] clr_now;
    assign clr_now = (wr_en && (wr_addr == A_CAUSE)) ? wr_data[NUM_PINS-1:0] : '0;

    // R10: a set cause bit survives unless a clear was written to it.
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(cause_q) & ~$past(clr_now)) & ~cause_q) == '0));

    // R9: a newly set cause bit belongs to an enabled pin.
    a_r9_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        (((cause_q & ~$past(cause_q)) & ~$past(en_q)) == '0));

    // R3: a newly set cause bit had its pin active in the previous cycle.
    a_r3_active_only: assert property (@(posedge clk) disable iff (!rst_n)
        (((cause_q & ~$past(cause_q)) & ~$past(active)) == '0));

    // R2: upper read bits of the cause register are zero.
    a_r2_cause_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_CAUSE) |-> (rd_data[REG_W-1:NUM_PINS] == '0));

    // R11: the request rises only when some pin was enabled.
    a_r11_req_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> ($past(en_q) != '0));

    // R11: the request falls only after a write to the cause register.
    a_r11_req_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_req) |-> ($past(wr_en) && ($past(wr_addr) == A_CAUSE)));
endmodule

bind wkdb_top wkdb_checker #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .REG_W    (REG_W)
) u_wkdb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wake_req (wake_req),
    .cause_q  (cause_q),
    .en_q     (en_q),
    .active   (pin_active)
);

// File: tb/tb_wkdb_top.sv
module tb_wkdb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LC1 = 2, LC2 = 3, LC3 = 5, LC4 = 7, LC5 = 9, LC6 = 12;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_addr = 0;
    logic [7:0]  wr_data = 0;
    logic [1:0]  rd_addr = 0;
    logic [15:0] rd_data;
    logic [7:0]  pins = 0;
    logic        wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wkdb_top #(.LEN_C1(LC1), .LEN_C2(LC2), .LEN_C3(LC3), .LEN_C4(LC4),
               .LEN_C5(LC5), .LEN_C6(LC6)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wake_pin(pins), .wake_req(wake_req));

    function automatic int exp_len(input logic [4:0] code);
        case (code)
            5'd0: return 1;
            5'd1: return LC1;
            5'd2: return LC2;
            5'd3: return LC3;
            5'd4: return LC4;
            5'd5: return LC5;
            default: return LC6;
        endcase
    endfunction

    // Reference model built from the requirements.
    logic [7:0] m_s1, m_s2, m_pol, m_en, m_cause;
    logic [4:0] m_code;
    int         m_run [8];
    always @(posedge clk) begin : model
        logic [7:0] q;
        logic [7:0] clr;
        bit act;
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_pol <= 0; m_en <= 0; m_cause <= 0; m_code <= 0;
            for (int i = 0; i < 8; i++) m_run[i] <= 0;
        end else begin
            for (int i = 0; i < 8; i++) begin
                act = (m_s2[i] == m_pol[i]);
                q[i] = act && (m_run[i] + 1 >= exp_len(m_code));
                m_run[i] <= act ? ((m_run[i] < 1000) ? m_run[i] + 1 : m_run[i]) : 0;
            end
            clr = (wr_en && wr_addr == 2'd3) ? wr_data : 8'h00;
            m_cause <= (m_cause & ~clr) | (q & m_en);
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_code <= wr_data[4:0];
                    2'd1: m_pol  <= wr_data;
                    2'd2: m_en   <= wr_data;
                    default: ;
                endcase
            end
            m_s1 <= pins;
            m_s2 <= m_s1;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // Idle all pins at the inactive level, configure, then clear causes.
    task automatic setup(input bit pol, input logic [7:0] en, input logic [4:0] code);
        pins = pol ? 8'h00 : 8'hFF;
        wr(2'd1, pol ? 8'hFF : 8'h00);
        wr(2'd2, en);
        wr(2'd0, {3'b000, code});
        repeat (4) @(negedge clk);
        wr(2'd3, 8'hFF);
    endtask

    task automatic pulse_case(input string tag, input int pin, input bit pol,
                              input logic [4:0] code, input int k);
        logic [15:0] v;
        setup(pol, 8'h01 << pin, code);
        pins[pin] = pol;
        repeat (k) @(negedge clk);
        pins[pin] = ~pol;
        repeat (4) @(negedge clk);
        rd(2'd3, v);
        chk(tag, v, (k >= exp_len(code)) ? (16'h0001 << pin) : 16'h0000);
        chk({tag, " R11 req"}, {15'd0, wake_req}, {15'd0, k >= exp_len(code)});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] v;
        int toggle_div;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 reset reg", v, 16'h0000);
        end
        chk("R1 reset req", {15'd0, wake_req}, 16'h0000);

        // R2: field widths and zero padding
        wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 code width", v, 16'h001F);
        wr(2'd1, 8'hA5); rd(2'd1, v); chk("R2 level reg", v, 16'h00A5);
        wr(2'd2, 8'h3C); rd(2'd2, v); chk("R2 enable reg", v, 16'h003C);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);

        // R4: synchronizer latency with code 0
        setup(1'b1, 8'h01, 5'd0);
        pins[0] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(2'd3, v); chk("R4 not yet after two edges", v, 16'h0000);
        @(negedge clk);
        rd(2'd3, v); chk("R4 set at third edge", v, 16'h0001);
        chk("R11 req high", {15'd0, wake_req}, 16'h0001);

        // R10: set wins over clear, sticky, write-one-to-clear
        wr(2'd3, 8'h01); rd(2'd3, v); chk("R10 set wins over clear", v, 16'h0001);
        pins[0] = 1'b0;
        repeat (4) @(negedge clk);
        wr(2'd3, 8'h00); rd(2'd3, v); chk("R10 write zero ignored", v, 16'h0001);
        wr(2'd3, 8'hFE); rd(2'd3, v); chk("R10 other bits ignored", v, 16'h0001);
        wr(2'd3, 8'h01); rd(2'd3, v); chk("R10 cleared", v, 16'h0000);
        chk("R11 req low", {15'd0, wake_req}, 16'h0000);

        // R5: one cycle is enough with code 0
        pulse_case("R5 single cycle", 2, 1'b1, 5'd0, 1);

        // R6: each code at its length and one short
        for (int c = 1; c <= 6; c++) begin
            pulse_case("R6 one short", c, 1'b1, c[4:0], exp_len(c[4:0]) - 1);
            pulse_case("R6 exact", c, 1'b1, c[4:0], exp_len(c[4:0]));
        end

        // R7: reserved codes behave as code 6
        pulse_case("R7 code7 short", 4, 1'b1, 5'd7, LC6 - 1);
        pulse_case("R7 code7 exact", 4, 1'b1, 5'd7, LC6);
        pulse_case("R7 code31 short", 6, 1'b1, 5'd31, LC6 - 1);
        pulse_case("R7 code31 long", 6, 1'b1, 5'd31, LC6 + 20);

        // R3: active-low pin, and a pin held at the wrong level
        pulse_case("R3 active low", 5, 1'b0, 5'd2, LC2);
        setup(1'b1, 8'h20, 5'd0);
        pins[5] = 1'b0;
        repeat (10) @(negedge clk);
        rd(2'd3, v); chk("R3 wrong level ignored", v, 16'h0000);

        // R8: counter restarts after one inactive cycle
        setup(1'b1, 8'h08, 5'd3);
        pins[3] = 1'b1; repeat (LC3 - 1) @(negedge clk);
        pins[3] = 1'b0; @(negedge clk);
        pins[3] = 1'b1; repeat (LC3 - 1) @(negedge clk);
        pins[3] = 1'b0; repeat (4) @(negedge clk);
        rd(2'd3, v); chk("R8 split run", v, 16'h0000);

        // R9: disabled pin
        setup(1'b1, 8'hFE, 5'd0);
        pins[0] = 1'b1; repeat (8) @(negedge clk);
        pins[0] = 1'b0; repeat (4) @(negedge clk);
        rd(2'd3, v); chk("R9 disabled pin", v, 16'h0000);

        // R12: independent per-pin counting
        setup(1'b1, 8'h03, 5'd3);
        pins[0] = 1'b1; pins[1] = 1'b1;
        repeat (LC3 - 1) @(negedge clk);
        pins[1] = 1'b0;
        @(negedge clk);
        pins[0] = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd3, v); chk("R12 independent pins", v, 16'h0001);

        // Random phase against the reference model (R3, R6, R7, R9, R10, R11)
        wr(2'd3, 8'hFF);
        rd_addr = 2'd3;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            #1;
            chk("R10 random cause", rd_data, {8'h00, m_cause});
            chk("R11 random req", {15'd0, wake_req}, {15'd0, m_cause != 0});
            toggle_div = ((c / 500) % 2 == 0) ? 3 : 40;
            for (int i = 0; i < 8; i++)
                if ($urandom % toggle_div == 0) pins[i] = ~pins[i];
            wr_en = ($urandom % 12 == 0);
            wr_addr = 2'($urandom);
            wr_data = 8'($urandom);
            if (wr_addr == 2'd0 && ($urandom % 2 == 0)) wr_data = 8'($urandom % 8);
        end
        @(negedge clk);
        wr_en = 0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule